// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block keeps time of day and calendar date as packed BCD bytes: hundredths of a second, seconds, minutes, 24-hour hours, date with a two-bit leap-cycle year, month with a three-bit weekday, and a day timer that counts to 99. A single-cycle input pulse advances the counters. The mode input decides how that pulse is used. In the crystal mode the pulse is a 32.768 kHz enable, and a fractional prescaler turns it into a 100 Hz step. In the mains mode each pulse is a 50 Hz tick that adds two hundredths. In the event mode each pulse adds one to a six-digit BCD count held in the three lowest counter bytes.

A host reaches the seven counter bytes through a small parallel port. Raising `rd_start` copies every counter into a snapshot at the same edge. `rd_data` then shows the snapshot byte selected by `addr`, so a multi-byte read never mixes values from before and after a carry. A write replaces only the addressed byte. All other counters keep advancing as if the write had not happened.

Top module: `rtc_count_core`

## Requirements
- R1: After a synchronous reset, the counter bytes at addresses 1 to 7 read 00, 00, 00, 00, 01, 01, 00. This is midnight on date 01, month 01, year count 0, weekday 0, with the timer at 0.
- R2: With mode = 2'b00, the hundredths count after n pulses from reset equals floor(n*100/32768). So 327 pulses give 00, 328 give 01, 655 give 01 and 656 give 02.
- R3: With mode = 2'b01, each pulse adds 2 to the hundredths. From 98 the hundredths become 00 and one carry goes into the seconds.
- R4: Seconds and minutes roll from 59 to 00 and carry onward. Hours roll from 23 to 00 and start a new day.
- R5: A new day moves the date to the next value, or to 01 past the month's last day. The last day is 31, or 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the year count is 0 and 28 otherwise. Past month 12 the month becomes 01 and the year count adds one modulo 4.
- R6: Each new day moves the weekday from 6 to 0, or adds one otherwise. It also adds one to the BCD timer, which rolls from 99 to 00.
- R7: With mode = 2'b10, each pulse adds one to a six-digit BCD value. The low two digits are at address 1, the middle two at address 2 and the high two at address 3. The value wraps from 999999 to 000000. Hours, date, month, weekday and timer do not change.
- R8: With mode = 2'b11, pulses change no counter.
- R9: Address map: 1 hundredths, 2 seconds, 3 minutes, 4 hours in bits 5:0 with bits 7:6 reading 0. Address 5 holds the year count in bits 7:6 and the date in bits 5:0. Address 6 holds the weekday in bits 7:5 and the month in bits 4:0. Address 7 is the timer, and address 0 reads 00.
- R10: A cycle with rd_start high copies all counters into the snapshot. The copy holds the values from before any advance in that same cycle. rd_data shows the snapshot until the next rd_start.
- R11: A write sets the addressed byte at the next edge and leaves every other byte unchanged. If the write lands in the same cycle as an advance, the written byte takes wr_data. The other bytes advance, with carries worked out from the old value of the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 crystal, 01 mains 50 Hz, 10 event count, 11 hold |
| src_pulse | input | 1 | Single-cycle advance pulse |
| addr | input | 3 | Counter address for read and write |
| rd_start | input | 1 | Capture all counters into the snapshot |
| rd_data | output | 8 | Snapshot byte selected by addr |
| wr_en | input | 1 | Write wr_data to the addressed counter |
| wr_data | input | 8 | Write data |

## Verification
Two collisions can happen in one cycle. The first is a host write arriving on the same edge as an advance pulse. The bench provokes it with the hundredths at 98 and a write of 45 to the hundredths, and expects the hundredths to read 45 while the seconds still take the carry. The second is a snapshot request landing on the same edge as an advance. The bench raises rd_start and src_pulse together and expects the pre-advance value, then takes a fresh snapshot and expects the advanced value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        MODE_XTAL  = 2'b00,
        MODE_MAINS = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_HOLD  = 2'b11
    } rtc_mode_e;

    typedef enum logic [1:0] {
        ADV_NONE,
        ADV_ONE,
        ADV_TWO,
        ADV_EVENT
    } adv_e;

    typedef struct packed {
        logic [7:0] timer;
        logic [2:0] wday;
        logic [4:0] month;
        logic [1:0] year;
        logic [5:0] date;
        logic [5:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
        logic [7:0] hund;
    } rtc_regs_t;

    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_HUND  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEC   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MIN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_HOUR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_YDATE = 3'd5;
    localparam logic [ADDR_W-1:0] A_WMON  = 3'd6;
    localparam logic [ADDR_W-1:0] A_TIMER = 3'd7;

    localparam rtc_regs_t RTC_RESET = '{
        timer: 8'h00, wday: 3'd0, month: 5'h01, year: 2'd0,
        date: 6'h01, hour: 6'h00, min: 8'h00, sec: 8'h00, hund: 8'h00
    };

    // Two-digit BCD add of a small step; bit 8 is the carry out of 99.
    function automatic logic [8:0] bcd_add(input logic [7:0] v, input logic [3:0] k);
        logic [4:0] lo;
        logic [3:0] hi;
        logic       c;
        lo = {1'b0, v[3:0]} + {1'b0, k};
        hi = v[7:4];
        c  = 1'b0;
        if (lo > 5'd9) begin
            lo = lo - 5'd10;
            hi = hi + 4'd1;
        end
        if (hi > 4'd9) begin
            hi = 4'd0;
            c  = 1'b1;
        end
        return {c, hi, lo[3:0]};
    endfunction

    // Step by one, returning to 00 with a carry once the last value is reached.
    function automatic logic [8:0] bcd_wrap(input logic [7:0] v, input logic [7:0] last);
        logic [8:0] s;
        s = bcd_add(v, 4'd1);
        if (v >= last) return 9'h100;
        return {1'b0, s[7:0]};
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [1:0] y);
        case (m)
            5'h02:                      return (y == 2'd0) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic [7:0] ctr_byte(input rtc_regs_t r, input logic [ADDR_W-1:0] a);
        case (a)
            A_HUND:  return r.hund;
            A_SEC:   return r.sec;
            A_MIN:   return r.min;
            A_HOUR:  return {2'b00, r.hour};
            A_YDATE: return {r.year, r.date};
            A_WMON:  return {r.wday, r.month};
            A_TIMER: return r.timer;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_pkg::*;
#(
    parameter int unsigned SRC_HZ  = 32768,
    parameter int unsigned TICK_HZ = 100
) (
    input  logic      clk,
    input  logic      rst,
    input  rtc_mode_e mode,
    input  logic      src_pulse,
    output adv_e      adv
);
    localparam int unsigned ACC_W = $clog2(SRC_HZ + TICK_HZ + 1);
    localparam logic [ACC_W-1:0] SRC_L  = ACC_W'(SRC_HZ);
    localparam logic [ACC_W-1:0] TICK_L = ACC_W'(TICK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    assign sum  = acc + TICK_L;
    assign wrap = (sum >= SRC_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (mode != MODE_XTAL) begin
            acc <= '0;
        end else if (src_pulse) begin
            acc <= wrap ? (sum - SRC_L) : sum;
        end
    end

    always_comb begin
        case (mode)
            MODE_XTAL:  adv = (src_pulse && wrap) ? ADV_ONE : ADV_NONE;
            MODE_MAINS: adv = src_pulse ? ADV_TWO : ADV_NONE;
            MODE_EVENT: adv = src_pulse ? ADV_EVENT : ADV_NONE;
            default:    adv = ADV_NONE;
        endcase
    end

    // R8
    no_spurious_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (adv != ADV_NONE) |-> (src_pulse && mode != MODE_HOLD));

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_XTAL && src_pulse && !wrap) |=> (acc == $past(sum)));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  adv_e              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output rtc_regs_t         regs
);
    rtc_regs_t  nxt;
    logic [8:0] t_h, t_s, t_m, t_hr, t_t, t_mo, t_d;
    logic [5:0] last_d;
    logic       day_c;

    always_comb begin
        nxt    = regs;
        t_h    = '0;
        t_s    = '0;
        t_m    = '0;
        t_hr   = '0;
        t_t    = '0;
        t_mo   = '0;
        t_d    = '0;
        last_d = '0;
        day_c  = 1'b0;
        case (adv)
            ADV_ONE, ADV_TWO: begin
                t_h = bcd_add(regs.hund, (adv == ADV_TWO) ? 4'd2 : 4'd1);
                nxt.hund = t_h[7:0];
                if (t_h[8]) begin
                    t_s = bcd_wrap(regs.sec, 8'h59);
                    nxt.sec = t_s[7:0];
                    if (t_s[8]) begin
                        t_m = bcd_wrap(regs.min, 8'h59);
                        nxt.min = t_m[7:0];
                        if (t_m[8]) begin
                            t_hr = bcd_wrap({2'b00, regs.hour}, 8'h23);
                            nxt.hour = t_hr[5:0];
                            day_c = t_hr[8];
                        end
                    end
                end
                if (day_c) begin
                    last_d = month_last(regs.month, regs.year);
                    nxt.wday = (regs.wday >= 3'd6) ? 3'd0 : regs.wday + 3'd1;
                    t_t = bcd_add(regs.timer, 4'd1);
                    nxt.timer = t_t[7:0];
                    if (regs.date >= last_d) begin
                        nxt.date = 6'h01;
                        if (regs.month >= 5'h12) begin
                            nxt.month = 5'h01;
                            nxt.year  = regs.year + 2'd1;
                        end else begin
                            t_mo = bcd_add({3'b000, regs.month}, 4'd1);
                            nxt.month = t_mo[4:0];
                        end
                    end else begin
                        t_d = bcd_add({2'b00, regs.date}, 4'd1);
                        nxt.date = t_d[5:0];
                    end
                end
            end
            ADV_EVENT: begin
                t_h = bcd_add(regs.hund, 4'd1);
                nxt.hund = t_h[7:0];
                if (t_h[8]) begin
                    t_s = bcd_add(regs.sec, 4'd1);
                    nxt.sec = t_s[7:0];
                    if (t_s[8]) begin
                        t_m = bcd_add(regs.min, 4'd1);
                        nxt.min = t_m[7:0];
                    end
                end
            end
            default: ;
        endcase
        if (wr_en) begin
            case (wr_addr)
                A_HUND:  nxt.hund = wr_data;
                A_SEC:   nxt.sec  = wr_data;
                A_MIN:   nxt.min  = wr_data;
                A_HOUR:  nxt.hour = wr_data[5:0];
                A_YDATE: {nxt.year, nxt.date} = wr_data;
                A_WMON:  {nxt.wday, nxt.month} = wr_data;
                A_TIMER: nxt.timer = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= RTC_RESET;
        else     regs <= nxt;
    end

    // R11
    wr_hund_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_HUND) |=> (regs.hund == $past(wr_data)));

    // R11
    wr_timer_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adv == ADV_NONE && wr_addr != A_TIMER) |=> $stable(regs.timer));

    // R4
    sec_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (adv == ADV_TWO && regs.hund == 8'h98 && regs.sec == 8'h59 && !wr_en)
        |=> (regs.sec == 8'h00));

    // R7
    event_hour_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv == ADV_EVENT && !wr_en) |=> $stable(regs.hour));

endmodule

// File: rtl/rtc_snap_latch.sv
module rtc_snap_latch
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  rtc_regs_t         live,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    rtc_regs_t snap;

    always_ff @(posedge clk) begin
        if (rst)          snap <= RTC_RESET;
        else if (capture) snap <= live;
    end

    assign rd_data = ctr_byte(snap, rd_addr);

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(snap));

    // R10
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> (snap == $past(live)));

endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
    import rtc_pkg::*;
#(
    parameter int unsigned SRC_HZ  = 32768,
    parameter int unsigned TICK_HZ = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       src_pulse,
    input  logic [2:0] addr,
    input  logic       rd_start,
    output logic [7:0] rd_data,
    input  logic       wr_en,
    input  logic [7:0] wr_data
);
    adv_e      adv;
    rtc_regs_t live;
    rtc_mode_e mode_e;

    assign mode_e = rtc_mode_e'(mode);

    rtc_tick_gen #(
        .SRC_HZ (SRC_HZ),
        .TICK_HZ(TICK_HZ)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .src_pulse(src_pulse),
        .adv      (adv)
    );

    rtc_time_chain u_chain (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .wr_en  (wr_en),
        .wr_addr(addr),
        .wr_data(wr_data),
        .regs   (live)
    );

    rtc_snap_latch u_snap (
        .clk    (clk),
        .rst    (rst),
        .capture(rd_start),
        .live   (live),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

endmodule

// File: tb/rtc_count_core_tb_top.sv
module rtc_count_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       src_pulse = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       rd_start = 1'b0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rtc_count_core dut_i (
        .clk(clk), .rst(rst), .mode(mode), .src_pulse(src_pulse),
        .addr(addr), .rd_start(rd_start), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    // {init bytes a7..a1, expected bytes a7..a1}; one 50 Hz pulse in between
    localparam logic [111:0] VEC [8] = '{
        {56'h00_01_01_03_05_10_98, 56'h00_01_01_03_05_11_00},
        {56'h07_43_15_23_59_59_98, 56'h08_63_16_00_00_00_00},
        {56'h99_C2_68_23_59_59_98, 56'h00_03_41_00_00_00_00},
        {56'h00_22_28_23_59_59_98, 56'h01_42_29_00_00_00_00},
        {56'h05_42_29_23_59_59_98, 56'h06_63_01_00_00_00_00},
        {56'h10_92_F1_23_59_59_98, 56'h11_A1_01_00_00_00_00},
        {56'h00_04_B0_23_59_59_98, 56'h01_25_81_00_00_00_00},
        {56'h00_01_30_23_59_59_98, 56'h01_21_31_00_00_00_00}
    };
    localparam string VTAG [8] = '{
        "R3 carry into seconds", "R4 R6 day rollover", "R5 R6 Feb 28 year1",
        "R5 Feb 28 year0", "R5 Feb 29 year0", "R5 year wrap",
        "R5 30-day month", "R5 31-day month"
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_pulse = 1'b1;
        end
        @(negedge clk);
        src_pulse = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic capture();
        @(negedge clk);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rd_data;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] rexp [8];
        rexp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R9 address 0 reads zero
        capture();
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            check((a == 0) ? "R9 address 0" : "R1 reset value", v, rexp[a]);
        end

        // R2 crystal mode fractional prescale
        pulses(327); capture(); peek(3'd1, v); check("R2 327 pulses", v, 8'h00);
        pulses(1);   capture(); peek(3'd1, v); check("R2 328 pulses", v, 8'h01);
        pulses(327); capture(); peek(3'd1, v); check("R2 655 pulses", v, 8'h01);
        pulses(1);   capture(); peek(3'd1, v); check("R2 656 pulses", v, 8'h02);

        // Vector walk in mains mode: R3 R4 R5 R6 R9
        mode = 2'b01;
        for (int k = 0; k < 8; k++) begin
            for (int a = 1; a < 8; a++) write_reg(3'(a), VEC[k][56 + 8*(a-1) +: 8]);
            pulses(1);
            capture();
            for (int a = 1; a < 8; a++) begin
                peek(3'(a), v);
                check(VTAG[k], v, VEC[k][8*(a-1) +: 8]);
            end
        end

        // R7 event counting across bytes
        mode = 2'b10;
        write_reg(3'd4, 8'h07); write_reg(3'd7, 8'h33);
        write_reg(3'd3, 8'h12); write_reg(3'd2, 8'h99); write_reg(3'd1, 8'h98);
        pulses(3); capture();
        peek(3'd1, v); check("R7 event low", v, 8'h01);
        peek(3'd2, v); check("R7 event mid", v, 8'h00);
        peek(3'd3, v); check("R7 event high", v, 8'h13);
        peek(3'd4, v); check("R7 hours untouched", v, 8'h07);
        peek(3'd7, v); check("R7 timer untouched", v, 8'h33);
        write_reg(3'd3, 8'h99); write_reg(3'd2, 8'h99); write_reg(3'd1, 8'h99);
        pulses(1); capture();
        peek(3'd1, v); check("R7 wrap low", v, 8'h00);
        peek(3'd2, v); check("R7 wrap mid", v, 8'h00);
        peek(3'd3, v); check("R7 wrap high", v, 8'h00);

        // R8 hold mode
        write_reg(3'd1, 8'h42);
        mode = 2'b11;
        pulses(5); capture();
        peek(3'd1, v); check("R8 hold hundredths", v, 8'h42);
        peek(3'd4, v); check("R8 hold hours", v, 8'h07);

        // R10 snapshot holds between captures
        mode = 2'b01;
        write_reg(3'd1, 8'h10);
        capture();
        pulses(3);
        peek(3'd1, v); check("R10 snapshot held", v, 8'h10);
        capture(); peek(3'd1, v); check("R10 fresh snapshot", v, 8'h16);

        // R10 capture in the same cycle as an advance
        write_reg(3'd1, 8'h20);
        @(negedge clk); rd_start = 1'b1; src_pulse = 1'b1; addr = 3'd1;
        @(negedge clk); rd_start = 1'b0; src_pulse = 1'b0;
        peek(3'd1, v); check("R10 pre-advance capture", v, 8'h20);
        capture(); peek(3'd1, v); check("R10 post-advance capture", v, 8'h22);

        // R11 write colliding with an advance
        write_reg(3'd2, 8'h10); write_reg(3'd3, 8'h27); write_reg(3'd1, 8'h98);
        @(negedge clk); wr_en = 1'b1; addr = 3'd1; wr_data = 8'h45; src_pulse = 1'b1;
        @(negedge clk); wr_en = 1'b0; src_pulse = 1'b0;
        capture();
        peek(3'd1, v); check("R11 written byte wins", v, 8'h45);
        peek(3'd2, v); check("R11 carry from old value", v, 8'h11);

        // R11 plain write leaves neighbours alone
        write_reg(3'd2, 8'h33);
        capture();
        peek(3'd2, v); check("R11 write lands", v, 8'h33);
        peek(3'd3, v); check("R11 minutes unchanged", v, 8'h27);
        peek(3'd1, v); check("R11 hundredths unchanged", v, 8'h45);

        summary();
        $finish;
    end

endmodule